// File: doc/BRIEF.md
# Modulo Circular Address Generator

This block produces the address a DMA channel uses for its next unit transfer. It takes the current address and adds the unit size to it. It can optionally confine the result to an aligned power-of-two window, so that a channel can walk a circular queue again and again without software reloading the pointer. Each channel instantiates one copy for its source pointer and one for its destination pointer. Each copy is driven by its own window code.

The window code is four bits wide:

- A code of zero turns the wrap off. The sum then propagates through the full address width.
- A nonzero code `c` selects a window of 2^(c+3) bytes. That covers 16 bytes at code 1 up to 256 KB at code 15.
- When the wrap is on, only the address bits below the window size take the incremented value. The bits above are carried over from the current address, and any carry out of the window is discarded.

With the increment enable low, the address passes through untouched. The block is combinational by default. A parameter adds one output register for timing closure.

Top module: `mod_addr_gen`

## Requirements
- R1: When `incEn` is low, `nextAddr` equals `curAddr`, for every `modCode` and `sizeLog2`.
- R2: When `incEn` is high and `modCode` is 0, `nextAddr` equals `curAddr` plus the step size, modulo 2^ADDR_W.
- R3: When `incEn` is high and `modCode` is c in 1..15, the window is 2^(c+3) bytes. Code 1 gives 16 B, code 6 gives 512 B and code 15 gives 256 KB. Address bits below the window size equal the same bits of `curAddr` plus the step size.
- R4: With a nonzero `modCode`, all address bits at and above the window size are kept from `curAddr`. A carry out of the window never reaches them.
- R5: `sizeLog2` selects the step size. Values 0, 1, 2 and 3 mean steps of 1, 2, 4 and 8 bytes.
- R6: Feeding `nextAddr` back as `curAddr` with a nonzero code returns to the starting address after window/step steps. This holds for a start that is not aligned to the window.
- R7: With `REGISTERED`=1, `nextAddr` shows the result for the inputs present at the previous rising clock edge.
- R8: With `REGISTERED`=1, `nextAddr` is 0 while `rstN` is low.
- R9: With `REGISTERED`=0, `nextAddr` follows the inputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the registered variant |
| rstN | input | 1 | Active-low reset of the output register |
| curAddr | input | ADDR_W | Address of the transfer just made |
| sizeLog2 | input | 2 | Step size code, step = 1 << sizeLog2 bytes |
| incEn | input | 1 | Advance the address when high |
| modCode | input | 4 | Window code, 0 = no wrap, c = 2^(c+3) bytes |
| nextAddr | output | ADDR_W | Address for the next transfer |

## Verification
The hardest situation to reach from the ports is a carry leaving the window at the largest codes. At code 15 a carry out of bit 17 must be dropped while bits above stay intact. Random addresses rarely hit such a boundary, so directed cases place the address a single step below the window edge, both at code 1 and at code 15, with nonzero high bits. In a closed-loop sweep the bench feeds the output back as the next input from an unaligned start, so the queue has to come back to its origin. A random phase then covers every code and size against the behavioural model on every clock.

// File: rtl/amg_pkg.sv
package amg_pkg;
  localparam int MOD_CODE_W  = 4;
  localparam int SIZE_CODE_W = 2;
  localparam int WIN_BASE    = 3;  // code c selects 2^(c+WIN_BASE) bytes
  localparam int WIN_LOG2_W  = 7;

  typedef struct packed {
    logic                    advance;
    logic                    wrapOn;
    logic [WIN_LOG2_W-1:0]   winLog2;
    logic [SIZE_CODE_W-1:0]  stepLog2;
  } amg_strobes_t;
endpackage

// File: rtl/amg_ctrl.sv
module amg_ctrl
  import amg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   incEn,
  input  logic [SIZE_CODE_W-1:0] sizeLog2,
  input  logic [MOD_CODE_W-1:0]  modCode,
  output amg_strobes_t           strobes
);
  localparam logic [WIN_LOG2_W-1:0] WIN_MAX = WIN_LOG2_W'(ADDR_W);

  logic [WIN_LOG2_W-1:0] winRaw;
  logic [WIN_LOG2_W-1:0] winClip;

  assign winRaw  = WIN_LOG2_W'(modCode) + WIN_LOG2_W'(WIN_BASE);
  assign winClip = (winRaw > WIN_MAX) ? WIN_MAX : winRaw;

  always_comb begin
    strobes.advance  = incEn;
    strobes.wrapOn   = (modCode != '0);
    strobes.winLog2  = winClip;
    strobes.stepLog2 = sizeLog2;
  end
endmodule

// File: rtl/amg_datapath.sv
module amg_datapath
  import amg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit REGISTERED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] curAddr,
  input  amg_strobes_t      strobes,
  output logic [ADDR_W-1:0] nextAddr
);
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] sumAddr;
  logic [ADDR_W-1:0] mixAddr;

  assign stepVal = ADDR_W'(1) << strobes.stepLog2;
  assign sumAddr = curAddr + stepVal;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    logic keepBit;
    assign keepBit    = !strobes.advance ||
                        (strobes.wrapOn && (WIN_LOG2_W'(i) >= strobes.winLog2));
    assign mixAddr[i] = keepBit ? curAddr[i] : sumAddr[i];
  end

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) nextAddr <= '0;
      else       nextAddr <= mixAddr;
    end
  end else begin : g_comb
    logic unusedPins;
    assign unusedPins = clk ^ rstN;
    assign nextAddr   = mixAddr;
  end
endmodule

// File: rtl/mod_addr_gen.sv
module mod_addr_gen
  import amg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit REGISTERED = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      curAddr,
  input  logic [SIZE_CODE_W-1:0] sizeLog2,
  input  logic                   incEn,
  input  logic [MOD_CODE_W-1:0]  modCode,
  output logic [ADDR_W-1:0]      nextAddr
);
  amg_strobes_t strobes;

  amg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .incEn    (incEn),
    .sizeLog2 (sizeLog2),
    .modCode  (modCode),
    .strobes  (strobes)
  );

  amg_datapath #(.ADDR_W(ADDR_W), .REGISTERED(REGISTERED)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .curAddr  (curAddr),
    .strobes  (strobes),
    .nextAddr (nextAddr)
  );
endmodule

// File: rtl/mod_addr_gen_chk.sv
module mod_addr_gen_chk #(
  parameter int ADDR_W     = 32,
  parameter bit REGISTERED = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] curAddr,
  input logic [1:0]        sizeLog2,
  input logic              incEn,
  input logic [3:0]        modCode,
  input logic [ADDR_W-1:0] nextAddr
);
  logic [ADDR_W-1:0] dCur;
  logic [1:0]        dSize;
  logic              dInc;
  logic [3:0]        dCode;
  logic              dValid;
  logic [ADDR_W-1:0] loMask;
  logic [ADDR_W-1:0] stepOf;

  if (REGISTERED) begin : g_delay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dValid <= 1'b0;
        dCur   <= '0;
        dSize  <= '0;
        dInc   <= 1'b0;
        dCode  <= '0;
      end else begin
        dValid <= 1'b1;
        dCur   <= curAddr;
        dSize  <= sizeLog2;
        dInc   <= incEn;
        dCode  <= modCode;
      end
    end
  end else begin : g_now
    assign dValid = 1'b1;
    assign dCur   = curAddr;
    assign dSize  = sizeLog2;
    assign dInc   = incEn;
    assign dCode  = modCode;
  end

  assign loMask = (ADDR_W'(1) << (int'(dCode) + 3)) - ADDR_W'(1);
  assign stepOf = ADDR_W'(1) << dSize;

  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && !dInc) |-> (nextAddr == dCur));

  a_r2_linear: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && dInc && dCode == 4'd0) |-> (nextAddr == dCur + stepOf));

  a_r3_low_advance: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && dInc && dCode != 4'd0) |-> (((nextAddr - dCur) & loMask) == (stepOf & loMask)));

  a_r4_high_kept: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && dInc && dCode != 4'd0) |-> (((nextAddr ^ dCur) & ~loMask) == '0));
endmodule

bind mod_addr_gen mod_addr_gen_chk #(.ADDR_W(ADDR_W), .REGISTERED(REGISTERED)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .curAddr  (curAddr),
  .sizeLog2 (sizeLog2),
  .incEn    (incEn),
  .modCode  (modCode),
  .nextAddr (nextAddr)
);

// File: tb/test_mod_addr_gen.sv
`timescale 1ns/1ps
module test_mod_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cur = '0;
  logic [1:0]  sz = '0;
  logic        inc = 1'b0;
  logic [3:0]  code = '0;
  logic [31:0] outComb;
  logic [31:0] outReg;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  mod_addr_gen i_mod_addr_gen (
    .clk(clk), .rstN(rstN), .curAddr(cur), .sizeLog2(sz),
    .incEn(inc), .modCode(code), .nextAddr(outComb));

  mod_addr_gen #(.REGISTERED(1'b1)) i_mod_addr_gen_reg (
    .clk(clk), .rstN(rstN), .curAddr(cur), .sizeLog2(sz),
    .incEn(inc), .modCode(code), .nextAddr(outReg));

  function automatic logic [31:0] refNext(logic [31:0] a, int s, bit en, int c);
    longint unsigned av, step, win;
    av   = longint'(a);
    step = 64'd1 << s;
    if (!en) return a;
    if (c == 0) return 32'((av + step) % (64'd1 << 32));
    win = 64'd1 << (c + 3);
    return 32'((av / win) * win + ((av % win) + step) % win);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, check comb path before any edge, registered path after the edge
  task automatic apply(logic [31:0] a, int s, bit en, int c, string tag);
    logic [31:0] exp;
    @(negedge clk);
    cur = a; sz = 2'(s); inc = en; code = 4'(c);
    exp = refNext(a, s, en, c);
    #2;
    check(tag, outComb, exp);
    @(posedge clk);
    #2;
    check({"R7 ", tag}, outReg, exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] start, p;
    cur = 32'h1234_5678; inc = 1'b1; code = 4'd3; sz = 2'd2;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset", outReg, 32'h0);
    check("R9 comb during reset", outComb, refNext(32'h1234_5678, 2, 1'b1, 3));
    @(negedge clk);
    rstN = 1'b1;

    apply(32'hDEAD_BEEF, 2, 1'b0, 5,  "R1 hold code5");
    apply(32'h0000_000F, 3, 1'b0, 0,  "R1 hold code0");
    apply(32'h1000_0000, 0, 1'b1, 0,  "R2 R5 step1");
    apply(32'h1000_0000, 1, 1'b1, 0,  "R2 R5 step2");
    apply(32'h1000_0000, 2, 1'b1, 0,  "R2 R5 step4");
    apply(32'h1000_0000, 3, 1'b1, 0,  "R2 R5 step8");
    apply(32'hFFFF_FFFE, 2, 1'b1, 0,  "R2 rollover");
    apply(32'h1000_000C, 2, 1'b1, 1,  "R3 R4 16B edge");
    apply(32'hABC3_FFFE, 1, 1'b1, 15, "R3 R4 256KB edge");
    apply(32'h5555_01FC, 2, 1'b1, 6,  "R3 512B edge");
    apply(32'h0000_001F, 1, 1'b1, 1,  "R4 unaligned");
    apply(32'h7000_0103, 3, 1'b1, 2,  "R3 32B mid");

    // closed-loop sweep of a 16-byte queue, 4-byte steps, unaligned start
    start = 32'h2000_0035;
    p = start;
    for (int k = 0; k < 4; k++) begin
      apply(p, 2, 1'b1, 1, "R6 sweep step");
      p = outComb;
    end
    check("R6 sweep return", p, start);

    // 64-byte queue with 8-byte steps, start at window edge
    start = 32'h3000_0078;
    p = start;
    for (int k = 0; k < 8; k++) begin
      apply(p, 3, 1'b1, 3, "R6 sweep64 step");
      p = outComb;
    end
    check("R6 sweep64 return", p, start);

    for (int k = 0; k < 400; k++) begin
      apply($urandom, int'($urandom % 4), bit'($urandom % 8 != 0),
            int'($urandom % 16), "R3 random");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule